// File: doc/BRIEF.md
# Multi-Channel Prescaled PWM Generator

This block produces several independent pulse-width-modulated outputs from one clock. Each channel owns a single 32-bit configuration word, written and read over a simple synchronous register port. The word holds the channel's run bit, an 8-bit high-time setting, a bit that holds the output high for the whole period, and a 13-bit clock divider.

Inside each channel, a prescaler emits one tick every divider+1 clocks. An 8-bit period counter advances once per tick, so one output period lasts 256 ticks. The output is high while the counter is below the high-time setting. Writing a channel's word, or stopping the channel, takes effect at the next clock edge. The period in progress is dropped rather than finished, and a write restarts the channel from the start of a fresh period.

Top module: `pwm_multi`

## Requirements
- R1: After reset every configuration word reads as zero and every `pwm_out` bit is low.
- R2: The configuration word layout is: divider in bits [12:0], high-time in bits [23:16], force-high in bit 24 and run in bit 31. A read returns the last value written, with bits [15:13] and [30:25] always zero. Read data appears on `bus_rdata` one clock after `bus_addr` is presented.
- R3: Channel n's word lives at byte address n*16. A write to any other address, including a nonzero low nibble or a channel number at or above `NUM_CH`, changes nothing, and a read of such an address returns zero.
- R4: While running, the prescaler gives one tick per divider+1 clocks, so the period counter advances once every divider+1 clocks.
- R5: One period lasts 256 ticks, and the output is high for the first high-time ticks of it. After a write that sets run, the output is high for high-time*(divider+1) cycles, starting with the cycle right after the write edge.
- R6: A high-time of zero without force-high keeps the output low for the entire period.
- R7: With force-high set on a running channel, the output stays high for the whole period whatever the high-time field holds.
- R8: Clearing the run bit drives the output low from the cycle right after the write edge, without finishing the period.
- R9: A write to a running channel restarts its prescaler and period counter from zero at that edge, and the new settings apply at once.
- R10: Channels are independent: writing or running one channel leaves every other channel's output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wen | input | 1 | Write strobe for the word at `bus_addr` |
| bus_addr | input | ADDR_W | Byte address of the channel word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| pwm_out | output | NUM_CH | One active-high PWM output per channel |

## Verification
The assertions check on every cycle that the prescaler count stays within the divider and that the period counter holds between ticks and steps by one on each tick. They also check that a restart or a stopped channel leaves the counter at zero, that reserved read bits stay zero, and that unmapped reads return zero. Only the bench scenarios can show the resulting waveform: the number of high cycles per period, where the falling edge lands, the force-high and zero high-time cases, the immediate effect of a rewrite or a stop, and the isolation between channels.

// File: rtl/pwm_ctrl_pkg.sv
package pwm_ctrl_pkg;

    localparam int DIV_W  = 13;
    localparam int DUTY_W = 8;

    // Layout of a channel configuration word (bit positions are fixed).
    typedef struct packed {
        logic              run;        // [31]
        logic [5:0]        rsv_hi;     // [30:25]
        logic              force_hi;   // [24]
        logic [DUTY_W-1:0] high_time;  // [23:16]
        logic [2:0]        rsv_lo;     // [15:13]
        logic [DIV_W-1:0]  divider;    // [12:0]
    } chan_cfg_t;

    function automatic chan_cfg_t clean_cfg(input logic [31:0] word);
        chan_cfg_t c;
        c        = chan_cfg_t'(word);
        c.rsv_hi = '0;
        c.rsv_lo = '0;
        return c;
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] divider,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] pre;
    } pre_state_t;

    pre_state_t st_q, st_d;

    assign tick = run && (st_q.pre == divider);

    always_comb begin
        st_d = st_q;
        if (!run || restart) begin
            st_d.pre = '0;
        end else if (tick) begin
            st_d.pre = '0;
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: the prescale count never passes the divider while running
    a_r4_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (st_q.pre <= divider));

    // R9: a restart clears the prescaler
    a_r9_pre_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.pre == '0));

endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr
    import pwm_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic              tick,
    input  logic [DUTY_W-1:0] high_time,
    input  logic              force_hi,
    output logic              pwm_o
);

    typedef struct packed {
        logic [DUTY_W-1:0] cnt;
    } ctr_state_t;

    ctr_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!run || restart) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pwm_o = run && (force_hi || (st_q.cnt < high_time));

    // R4: counter holds between ticks
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !restart && !tick) |=> (st_q.cnt == $past(st_q.cnt)));

    // R5: counter steps by one per tick, wrapping after 256 ticks
    a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !restart && tick) |=> (st_q.cnt == $past(st_q.cnt) + 8'd1));

    // R9: a restart begins a fresh period
    a_r9_cnt_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (st_q.cnt == '0));

    // R8: a stopped channel keeps its counter at zero
    a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (st_q.cnt == '0));

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic [DIV_W-1:0]  divider,
    input  logic [DUTY_W-1:0] high_time,
    input  logic              force_hi,
    output logic              pwm_o
);

    logic tick;

    pwm_prescaler u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (restart),
        .divider (divider),
        .tick    (tick)
    );

    pwm_period_ctr u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .restart   (restart),
        .tick      (tick),
        .high_time (high_time),
        .force_hi  (force_hi),
        .pwm_o     (pwm_o)
    );

endmodule

// File: rtl/pwm_multi.sv
module pwm_multi
    import pwm_ctrl_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wen,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    localparam int STRIDE_W = 4;                 // 16-byte stride
    localparam int CH_IDX_W = ADDR_W - STRIDE_W;

    typedef struct {
        chan_cfg_t   cfg [NUM_CH];
        logic [31:0] rdata;
    } top_state_t;

    top_state_t st_q, st_d;

    logic [CH_IDX_W-1:0] ch_idx;
    logic                addr_hit;
    logic [NUM_CH-1:0]   restart;

    assign ch_idx   = bus_addr[ADDR_W-1:STRIDE_W];
    assign addr_hit = (bus_addr[STRIDE_W-1:0] == '0) && (int'(ch_idx) < NUM_CH);

    always_comb begin
        st_d       = st_q;
        restart    = '0;
        st_d.rdata = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (addr_hit && (ch_idx == CH_IDX_W'(ch))) begin
                st_d.rdata = st_q.cfg[ch];
                if (bus_wen) begin
                    st_d.cfg[ch] = clean_cfg(bus_wdata);
                    restart[ch]  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int ch = 0; ch < NUM_CH; ch++) st_q.cfg[ch] <= '0;
            st_q.rdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            pwm_channel u_chan (
                .clk       (clk),
                .rst_n     (rst_n),
                .run       (st_q.cfg[g].run),
                .restart   (restart[g]),
                .divider   (st_q.cfg[g].divider),
                .high_time (st_q.cfg[g].high_time),
                .force_hi  (st_q.cfg[g].force_hi),
                .pwm_o     (pwm_out[g])
            );
        end
    endgenerate

    // R2: reserved bits never read back as one
    a_r2_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata[15:13] == 3'b0) && (bus_rdata[30:25] == 6'b0));

    // R3: unmapped addresses read as zero
    a_r3_miss_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_hit |=> (bus_rdata == 32'b0));

    // R10: at most one channel restarts per write
    a_r10_one_restart: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(restart));

endmodule

// File: tb/pwm_multi_test.sv
module pwm_multi_test;

    localparam int NUM_CH = 4;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wen = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NUM_CH-1:0] pwm_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    pwm_multi #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    function automatic logic [31:0] mk_word(bit run, bit full, int duty, int div);
        return {run, 6'b0, full, 8'(duty), 3'b0, 13'(div)};
    endfunction

    function automatic int exp_high(bit full, int duty, int div);
        return full ? 256 * (div + 1) : duty * (div + 1);
    endfunction

    function automatic int exp_fall(bit full, int duty, int div);
        return (full || duty == 0) ? -1 : duty * (div + 1);
    endfunction

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        bus_addr  = ADDR_W'(addr);
        bus_wdata = data;
        bus_wen   = 1'b1;
        @(negedge clk);
        bus_wen   = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [31:0] data);
        @(negedge clk);
        bus_addr = ADDR_W'(addr);
        @(negedge clk);
        data = bus_rdata;
    endtask

    // Samples at negedges starting with the one right after a write.
    task automatic measure(input int ch, input int cycles, output int high, output int fall);
        bit prev = 1'b0;
        high = 0;
        fall = -1;
        for (int i = 0; i < cycles; i++) begin
            if (pwm_out[ch]) high++;
            if (i > 0 && prev && !pwm_out[ch] && fall < 0) fall = i;
            prev = pwm_out[ch];
            @(negedge clk);
        end
    endtask

    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int high, fall, seed;
        seed = $urandom(32'h5eed);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check(pwm_out == '0, "R1 outputs low", pwm_out, 0);
        for (int ch = 0; ch < NUM_CH; ch++) begin
            rd(ch * 16, r);
            check(r == 32'b0, "R1 word zero", r, 0);
        end

        // R2: readback with reserved bits masked
        for (int i = 0; i < 6; i++) begin
            logic [31:0] w;
            int ch;
            w  = $urandom & 32'h7fff_ffff;  // keep channel stopped
            ch = $urandom_range(0, NUM_CH - 1);
            wr(ch * 16, w);
            rd(ch * 16, r);
            check(r == (w & 32'h81ff_1fff), "R2 readback", r, w & 32'h81ff_1fff);
        end

        // R3: unmapped writes ignored, reads zero
        wr(16, mk_word(0, 0, 77, 9));
        wr(16 + 4, 32'h7fff_ffff);
        wr(NUM_CH * 16, 32'h7fff_ffff);
        rd(16, r);
        check(r == mk_word(0, 0, 77, 9), "R3 misaligned write ignored", r, mk_word(0, 0, 77, 9));
        rd(16 + 4, r);
        check(r == 0, "R3 misaligned read zero", r, 0);
        rd(NUM_CH * 16, r);
        check(r == 0, "R3 out-of-range read zero", r, 0);
        for (int ch = 0; ch < NUM_CH; ch++) wr(ch * 16, 0);

        // R4/R5: directed divider 2, high-time 1 -> 3 high cycles
        wr(0, mk_word(1, 0, 1, 2));
        measure(0, 256 * 3, high, fall);
        check(high == 3, "R5 high count div2", high, 3);
        check(fall == 3, "R4 fall position div2", fall, 3);

        // R6: zero high-time
        wr(0, mk_word(1, 0, 0, 1));
        measure(0, 512, high, fall);
        check(high == 0, "R6 zero duty stays low", high, 0);

        // R7: force-high ignores high-time
        wr(0, mk_word(1, 1, 5, 1));
        measure(0, 512, high, fall);
        check(high == 512, "R7 force-high full period", high, 512);

        // R8: stop drives output low at once
        wr(0, mk_word(0, 1, 5, 1));
        measure(0, 20, high, fall);
        check(high == 0, "R8 stop drives low", high, 0);

        // R9: rewrite mid-period restarts
        wr(0, mk_word(1, 0, 200, 1));
        repeat (50) @(negedge clk);
        wr(0, mk_word(1, 0, 10, 0));
        measure(0, 256, high, fall);
        check(high == 10, "R9 restart high count", high, 10);
        check(fall == 10, "R9 restart fall position", fall, 10);

        // R10: other channels hold while channel 0 runs and is rewritten
        wr(16, mk_word(1, 1, 0, 0));
        wr(32, mk_word(1, 0, 0, 0));
        wr(0, mk_word(1, 0, 128, 0));
        begin
            int bad = 0;
            for (int i = 0; i < 300; i++) begin
                if (pwm_out[1] !== 1'b1 || pwm_out[2] !== 1'b0 || pwm_out[3] !== 1'b0) bad++;
                if (i == 100) begin
                    bus_addr = 0; bus_wdata = mk_word(1, 0, 3, 2); bus_wen = 1'b1;
                end
                @(negedge clk);
                bus_wen = 1'b0;
            end
            check(bad == 0, "R10 channel isolation", bad, 0);
        end

        // R5 random: mixed channels and settings
        for (int i = 0; i < 14; i++) begin
            int ch, duty, div;
            bit full;
            ch   = $urandom_range(0, NUM_CH - 1);
            duty = (i == 0) ? 255 : $urandom_range(0, 255);
            div  = $urandom_range(0, 3);
            full = ($urandom_range(0, 7) == 0);
            wr(ch * 16, mk_word(1, full, duty, div));
            measure(ch, 256 * (div + 1), high, fall);
            check(high == exp_high(full, duty, div), "R5 random high count", high, exp_high(full, duty, div));
            check(fall == exp_fall(full, duty, div), "R4 random fall position", fall, exp_fall(full, duty, div));
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule